// File: doc/BRIEF.md
# Composite Colour Palette Phase Encoder

The block turns an 8-bit red, green and blue colour into the four composite-video sample codes that a 4×-subcarrier sampler needs for that colour. At four samples per subcarrier period, the subcarrier's sine and cosine take only the values 0, +1 and −1. Each sample is therefore the luminance plus or minus one weighted colour-difference term. All four codes of a colour are computed once and stored side by side. A pixel then costs a single palette read per sample.

A write request carries a palette slot and a colour. A short fixed-point pipeline computes the luminance first, then the two colour differences. After that it emits one code per cycle into four consecutive words, and a busy flag covers the whole sequence. The read side takes the pixel's palette slot and the running 2-bit subcarrier phase, and returns the 8-bit DAC code one clock later. The output scale, setup offset, DAC scale and blank level are parameters.

Top module: `pal_phase_encoder`

## Requirements
- R1: After synchronous reset, `busy` is 0 and every palette word reads back as 0.
- R2: Luminance is held in Q.12 as Y = 1225·R + 2404·G + 467·B.
- R3: The colour differences are U = floor(2016·(B·4096 − Y) / 4096) and V = floor(3593·(R·4096 − Y) / 4096), both in Q.12.
- R4: The composite value S is Y+V for phase 0, Y+U for phase 1, Y−V for phase 2 and Y−U for phase 3.
- R5: The code is C = floor(DAC_Q12·(floor(SCALE_Q12·S/4096) + SETUP·4096) / 2^24) + BLANK, where each floor rounds toward minus infinity.
- R6: A C below 0 is stored as 0.
- R7: A C above 255 is stored as 255.
- R8: The code for slot i and phase p is stored at word 4·i + p, read with `rd_index`=i and `rd_phase`=p. A write changes no other slot.
- R9: In the cycle after a request is accepted while idle, `busy` goes high. It stays high for exactly 6 cycles, and the new codes are readable once it is low.
- R10: A request made while `busy` is high is ignored, and no slot changes because of it.
- R11: `rd_code` shows the word addressed at the previous rising clock edge.
- R12: When a word is read and written at the same edge, the read returns its previous contents. The new code appears on the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Request to compute and store a colour |
| wr_index | input | IDX_W | Target palette slot |
| wr_red | input | 8 | Red component |
| wr_green | input | 8 | Green component |
| wr_blue | input | 8 | Blue component |
| busy | output | 1 | High while a colour is being computed and stored |
| rd_index | input | IDX_W | Pixel palette slot |
| rd_phase | input | 2 | Subcarrier phase of the sample |
| rd_code | output | 8 | Registered DAC code |

## Verification
A pixel read and a palette store can hit the same word at the same clock edge. This happens when a display reads a slot that is being reprogrammed. The bench sets up this case by holding the read address on phase 0 of the slot being rewritten. Counted from the accept edge, that word is written at the third edge. The bench expects the old code right after that edge and the new code one edge later. A second request is also issued in the middle of a busy period, and the slot it names is checked afterwards to confirm it was left unchanged.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam longint KR_Q12 = 1225;
    localparam longint KG_Q12 = 2404;
    localparam longint KB_Q12 = 467;
    localparam longint KU_Q12 = 2016;
    localparam longint KV_Q12 = 3593;
    localparam int     FRAC   = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LUMA,
        ST_CHROMA,
        ST_EMIT
    } enc_state_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

    function automatic longint luma_q12(rgb_t c);
        return KR_Q12 * longint'(c.red) + KG_Q12 * longint'(c.green)
             + KB_Q12 * longint'(c.blue);
    endfunction

    function automatic longint diff_q12(longint coef, logic [7:0] comp, longint y);
        longint d;
        d = (longint'(comp) <<< FRAC) - y;
        return (coef * d) >>> FRAC;
    endfunction

endpackage

// File: rtl/pal_colour_split.sv
module pal_colour_split
    import pal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   luma_en,
    input  logic   chroma_en,
    input  rgb_t   colour,
    output longint y_q,
    output longint u_q,
    output longint v_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= 0;
            u_q <= 0;
            v_q <= 0;
        end else begin
            if (luma_en)
                y_q <= luma_q12(colour);
            if (chroma_en) begin
                u_q <= diff_q12(KU_Q12, colour.blue, y_q);
                v_q <= diff_q12(KV_Q12, colour.red, y_q);
            end
        end
    end

    // R3
    chroma_after_luma_chk: assert property (@(posedge clk) disable iff (rst)
        chroma_en |-> $past(luma_en));

endmodule

// File: rtl/pal_sample_shaper.sv
module pal_sample_shaper
    import pal_pkg::*;
#(
    parameter int SCALE_Y_Q12   = 3072,
    parameter int SETUP_LVL     = 10,
    parameter int DAC_SCALE_Q12 = 4096,
    parameter int BLANK_LVL     = 10
) (
    input  longint     y_in,
    input  longint     u_in,
    input  longint     v_in,
    input  logic [1:0] phase,
    output logic [7:0] code
);

    localparam longint SETUP_Q12 = longint'(SETUP_LVL) <<< FRAC;

    longint comp_s;
    longint scaled;
    longint dac_raw;

    always_comb begin
        unique case (phase)
            2'd0:    comp_s = y_in + v_in;
            2'd1:    comp_s = y_in + u_in;
            2'd2:    comp_s = y_in - v_in;
            default: comp_s = y_in - u_in;
        endcase
        scaled  = ((longint'(SCALE_Y_Q12) * comp_s) >>> FRAC) + SETUP_Q12;
        dac_raw = ((scaled * longint'(DAC_SCALE_Q12)) >>> (2 * FRAC))
                + longint'(BLANK_LVL);
        if (dac_raw < 0)
            code = 8'd0;
        else if (dac_raw > 255)
            code = 8'd255;
        else
            code = 8'(dac_raw);
    end

endmodule

// File: rtl/pal_word_store.sv
module pal_word_store #(
    parameter int ADDR_W = 6,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [7:0]        wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [7:0]        rd_q
);

    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < WORDS; k++)
                mem[k] <= 8'd0;
            rd_q <= 8'd0;
        end else begin
            if (we)
                mem[wa] <= wd;
            rd_q <= mem[ra];
        end
    end

endmodule

// File: rtl/pal_phase_encoder.sv
module pal_phase_encoder
    import pal_pkg::*;
#(
    parameter int IDX_W         = 4,
    parameter int SCALE_Y_Q12   = 3072,
    parameter int SETUP_LVL     = 10,
    parameter int DAC_SCALE_Q12 = 4096,
    parameter int BLANK_LVL     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [7:0]       wr_red,
    input  logic [7:0]       wr_green,
    input  logic [7:0]       wr_blue,
    output logic             busy,
    input  logic [IDX_W-1:0] rd_index,
    input  logic [1:0]       rd_phase,
    output logic [7:0]       rd_code
);

    localparam int ADDR_W = IDX_W + 2;

    enc_state_e       st_q;
    logic [IDX_W-1:0] idx_q;
    rgb_t             col_q;
    logic [1:0]       ph_q;
    longint           y_w, u_w, v_w;
    logic [7:0]       code_w;
    logic             we_w;

    assign busy = (st_q != ST_IDLE);
    assign we_w = (st_q == ST_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            col_q <= '0;
            ph_q  <= 2'd0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (wr_req) begin
                    idx_q <= wr_index;
                    col_q <= '{red: wr_red, green: wr_green, blue: wr_blue};
                    st_q  <= ST_LUMA;
                end
                ST_LUMA:   st_q <= ST_CHROMA;
                ST_CHROMA: begin
                    ph_q <= 2'd0;
                    st_q <= ST_EMIT;
                end
                default: begin
                    ph_q <= ph_q + 2'd1;
                    if (ph_q == 2'd3)
                        st_q <= ST_IDLE;
                end
            endcase
        end
    end

    pal_colour_split u_split (
        .clk       (clk),
        .rst       (rst),
        .luma_en   (st_q == ST_LUMA),
        .chroma_en (st_q == ST_CHROMA),
        .colour    (col_q),
        .y_q       (y_w),
        .u_q       (u_w),
        .v_q       (v_w)
    );

    pal_sample_shaper #(
        .SCALE_Y_Q12   (SCALE_Y_Q12),
        .SETUP_LVL     (SETUP_LVL),
        .DAC_SCALE_Q12 (DAC_SCALE_Q12),
        .BLANK_LVL     (BLANK_LVL)
    ) u_shape (
        .y_in  (y_w),
        .u_in  (u_w),
        .v_in  (v_w),
        .phase (ph_q),
        .code  (code_w)
    );

    pal_word_store #(.ADDR_W(ADDR_W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (we_w),
        .wa   ({idx_q, ph_q}),
        .wd   (code_w),
        .ra   ({rd_index, rd_phase}),
        .rd_q (rd_code)
    );

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_req) |=> busy);

    // R9
    emit_end_chk: assert property (@(posedge clk) disable iff (rst)
        (we_w && ph_q == 2'd3) |=> !busy);

    // R10
    hold_target_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(idx_q) && $stable(col_q)));

    // R8
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (we_w && ph_q != 2'd3) |=> (we_w && ph_q == $past(ph_q) + 2'd1));

endmodule

// File: tb/pal_phase_encoder_test.sv
module pal_phase_encoder_test;

    localparam int IDX_W = 4;
    localparam int SLOTS = 1 << IDX_W;
    localparam int SCL = 3072, SET = 10, DAC = 4096, BLK = 10;

    logic             clk = 0;
    logic             rst = 1;
    logic             wr_req = 0;
    logic [IDX_W-1:0] wr_index = '0;
    logic [7:0]       wr_red = 0, wr_green = 0, wr_blue = 0;
    logic             busy;
    logic [IDX_W-1:0] rd_index = '0;
    logic [1:0]       rd_phase = 0;
    logic [7:0]       rd_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] shadow [SLOTS*4];

    always #4 clk = ~clk;

    pal_phase_encoder #(.IDX_W(IDX_W), .SCALE_Y_Q12(SCL), .SETUP_LVL(SET),
                        .DAC_SCALE_Q12(DAC), .BLANK_LVL(BLK)) uut (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_index(wr_index),
        .wr_red(wr_red), .wr_green(wr_green), .wr_blue(wr_blue),
        .busy(busy), .rd_index(rd_index), .rd_phase(rd_phase), .rd_code(rd_code));

    function automatic longint raw_code(logic [7:0] r, logic [7:0] g, logic [7:0] b, int ph);
        longint y, u, v, s, t;
        y = 1225 * longint'(r) + 2404 * longint'(g) + 467 * longint'(b);
        u = (2016 * ((longint'(b) <<< 12) - y)) >>> 12;
        v = (3593 * ((longint'(r) <<< 12) - y)) >>> 12;
        case (ph)
            0: s = y + v;
            1: s = y + u;
            2: s = y - v;
            default: s = y - u;
        endcase
        t = ((longint'(SCL) * s) >>> 12) + (longint'(SET) <<< 12);
        return ((t * longint'(DAC)) >>> 24) + longint'(BLK);
    endfunction

    function automatic logic [7:0] exp_code(logic [7:0] r, logic [7:0] g, logic [7:0] b, int ph);
        longint c;
        c = raw_code(r, g, b, ph);
        if (c < 0) return 8'd0;
        if (c > 255) return 8'd255;
        return 8'(c);
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic read_word(int idx, int ph, string tag);
        @(negedge clk);
        rd_index = IDX_W'(idx);
        rd_phase = 2'(ph);
        @(negedge clk);
        check(tag, rd_code, shadow[idx*4+ph]);
    endtask

    // write; if intr_idx >= 0, a second request to that slot is made mid-busy
    task automatic write_colour(int idx, logic [7:0] r, logic [7:0] g, logic [7:0] b, int intr_idx);
        @(negedge clk);
        wr_req = 1; wr_index = IDX_W'(idx);
        wr_red = r; wr_green = g; wr_blue = b;
        @(negedge clk);
        wr_req = 0;
        check("R9 busy after accept", busy, 1);
        for (int k = 1; k < 6; k++) begin
            @(negedge clk);
            if (k == 2 && intr_idx >= 0) begin
                wr_req = 1; wr_index = IDX_W'(intr_idx);
                wr_red = ~r; wr_green = ~g; wr_blue = 8'd77;
            end else begin
                wr_req = 0;
            end
            check("R9 busy held", busy, 1);
        end
        @(negedge clk);
        wr_req = 0;
        check("R9 busy low after six", busy, 0);
        for (int p = 0; p < 4; p++)
            shadow[idx*4+p] = exp_code(r, g, b, p);
    endtask

    task automatic verify_slot(int idx, logic [7:0] r, logic [7:0] g, logic [7:0] b);
        for (int p = 0; p < 4; p++) begin
            // R2 R3 R4 R5 R8 R11: code stored at 4*idx+p
            @(negedge clk);
            rd_index = IDX_W'(idx);
            rd_phase = 2'(p);
            @(negedge clk);
            check("R4 R5 R8 R11 phase code", rd_code, exp_code(r, g, b, p));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int k = 0; k < SLOTS*4; k++) shadow[k] = 8'd0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 busy at reset", busy, 0);
        for (int k = 0; k < SLOTS*4; k++)
            read_word(k / 4, k % 4, "R1 word cleared");

        // directed corners
        write_colour(1, 8'd255, 8'd0, 8'd0, -1);
        verify_slot(1, 8'd255, 8'd0, 8'd0);
        check("R6 red opposite phase clamps", shadow[1*4+2], 0);
        check("R6 raw below zero", raw_code(8'd255, 8'd0, 8'd0, 2) < 0, 1);

        write_colour(2, 8'd255, 8'd255, 8'd0, -1);
        verify_slot(2, 8'd255, 8'd255, 8'd0);
        check("R7 yellow phase 3 saturates", shadow[2*4+3], 255);
        check("R7 raw above max", raw_code(8'd255, 8'd255, 8'd0, 3) > 255, 1);

        write_colour(3, 8'd0, 8'd0, 8'd0, -1);
        verify_slot(3, 8'd0, 8'd0, 8'd0);
        write_colour(4, 8'd255, 8'd255, 8'd255, -1);
        verify_slot(4, 8'd255, 8'd255, 8'd255);
        write_colour(5, 8'd0, 8'd0, 8'd255, -1);
        verify_slot(5, 8'd0, 8'd0, 8'd255);

        // R10: request to slot 9 during busy must be dropped
        write_colour(6, 8'd30, 8'd200, 8'd90, 9);
        verify_slot(6, 8'd30, 8'd200, 8'd90);
        for (int p = 0; p < 4; p++)
            read_word(9, p, "R10 ignored request left slot");

        // R12: read and write of slot 1 phase 0 at the same edge
        @(negedge clk);
        rd_index = IDX_W'(1); rd_phase = 2'd0;
        wr_req = 1; wr_index = IDX_W'(1);
        wr_red = 8'd10; wr_green = 8'd250; wr_blue = 8'd40;
        @(negedge clk); wr_req = 0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R12 old word on collision", rd_code, shadow[4]);
        @(negedge clk);
        check("R12 new word next read", rd_code, exp_code(8'd10, 8'd250, 8'd40, 0));
        repeat (3) @(negedge clk);
        check("R9 idle after collision write", busy, 0);
        for (int p = 0; p < 4; p++) shadow[4+p] = exp_code(8'd10, 8'd250, 8'd40, p);
        verify_slot(1, 8'd10, 8'd250, 8'd40);

        // constrained random
        for (int n = 0; n < 40; n++) begin
            int idx, other;
            logic [7:0] r, g, b;
            idx = int'($urandom % SLOTS);
            r = 8'($urandom); g = 8'($urandom); b = 8'($urandom);
            if (n % 5 == 0) r = 8'd255;
            write_colour(idx, r, g, b, -1);
            verify_slot(idx, r, g, b);
            other = (idx + 1 + int'($urandom % (SLOTS - 1))) % SLOTS;
            read_word(other, int'($urandom % 4), "R8 other slot untouched");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule